// File: doc/BRIEF.md
# Bitmap Scan Address Generator

This block serves one page of a two-page bitmap overlay display. It runs on the display clock and watches the horizontal and vertical sync inputs. It counts display clocks from the latest active horizontal sync edge and scan lines from the latest active vertical sync edge. Each count is compared with a programmable start position. From these comparisons the block derives the page's display window, the word offset into a colour-bit plane, and the dot position within that word. The same offset and bit index apply to all nine colour planes, and one dot is produced per display clock.

Eight page geometries share one plane of 768 sixteen-bit words. A vertical size field repeats each bitmap row over one to four scan lines. The page control fields come in as plain inputs from the page's register set. Plane storage, colour mixing between the two pages and analogue or digital colour output all sit outside this block. The window, offset and bit select are combinational outputs of the counter state, so they describe the dot in the same cycle as the count.

Top module: `bitmap_scan_addr`

## Requirements
- R1: While `rst` is high, and after its release until the first active vertical sync edge, `in_window` is 0 and `word_off` and `bit_sel` are 0.
- R2: A sync input's active edge is its change to the level given by its polarity input (1 selects the rising edge, 0 the falling edge). A change to the other level clears no counter.
- R3: The column count C is the number of clock edges since the one that sampled the active horizontal edge, which gives C = 0. The page is horizontally inside when hstart <= C < hstart + width, and the dot column is C - hstart.
- R4: The line count L is the number of active horizontal edges since the active vertical edge, which gives L = 0. A horizontal edge that comes in the same cycle as the vertical edge does not advance L. The page is vertically inside when vstart <= L < vstart + height x rows-per-line-group.
- R5: `vsize` 00, 01, 10 and 11 make each bitmap row span 1, 2, 3 and 4 scan lines. The row is (L - vstart) / (vsize + 1).
- R6: `res_sel` 0 to 7 selects the width x height: 128x96, 192x64, 256x48, 384x32, 32x384, 48x256, 64x192 and 96x128.
- R7: Inside the window, `word_off` = row x (width / 16) + column / 16.
- R8: Inside the window, `bit_sel` = 15 - (column mod 16), so the leftmost dot of a word sits in bit 15.
- R9: With `disp_en` low, `in_window` is 0 and `word_off` and `bit_sel` are 0.
- R10: Outside the window, `word_off` and `bit_sel` are 0.
- R11: An active vertical edge in the middle of a line restarts the line count and leaves the column count running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync_in | input | 1 | Horizontal sync input |
| vsync_in | input | 1 | Vertical sync input |
| hsync_pol | input | 1 | Horizontal sync polarity, 1 = positive |
| vsync_pol | input | 1 | Vertical sync polarity, 1 = positive |
| res_sel | input | 3 | Page geometry select |
| vstart | input | 10 | Vertical start, in scan lines after vertical sync |
| hstart | input | 10 | Horizontal start, in display clocks after horizontal sync |
| vsize | input | 2 | Scan lines per bitmap row, minus one |
| disp_en | input | 1 | Page display enable |
| in_window | output | 1 | Current dot lies inside the page |
| word_off | output | 10 | Word offset within a colour-bit plane |
| bit_sel | output | 4 | Bit index of the current dot within the word |

## Verification
Every frame in the bench starts with the horizontal and vertical active edges in the same cycle. The line count must then restart at zero and the column count at zero, and that horizontal edge must not also advance the line count. The expected row is computed from the count of horizontal edges since the vertical edge. A second case fires the vertical edge in the middle of a line with no horizontal edge. There the row has to drop back at once while the word and bit inside the row keep moving, and the bench judges this by comparing the offset and bit on every cycle against its own division-based position model.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

    localparam int POS_W  = 10;   // start position fields
    localparam int ROW_W  = 9;    // bitmap rows, up to 384
    localparam int COLS_W = 9;    // bitmap columns, up to 384
    localparam int WPL_W  = 5;    // words per line, up to 24
    localparam int WOFF_W = 10;   // plane word offset, 768 words
    localparam int BIT_W  = 4;    // bit within a 16-dot word
    localparam int VSZ_W  = 2;    // vertical repeat field

    typedef enum logic [2:0] {
        RES_128X96  = 3'd0,
        RES_192X64  = 3'd1,
        RES_256X48  = 3'd2,
        RES_384X32  = 3'd3,
        RES_32X384  = 3'd4,
        RES_48X256  = 3'd5,
        RES_64X192  = 3'd6,
        RES_96X128  = 3'd7
    } res_e;

    typedef struct packed {
        logic [COLS_W-1:0] width;
        logic [ROW_W-1:0]  height;
        logic [WPL_W-1:0]  wpl;
    } geom_t;

    typedef struct packed {
        logic              active;
        logic [COLS_W-1:0] col;
    } hpos_t;

    typedef struct packed {
        logic             active;
        logic [ROW_W-1:0] row;
    } vpos_t;

    function automatic geom_t geom_of(input res_e r);
        geom_t g;
        case (r)
            RES_128X96: begin g.width = 9'd128; g.height = 9'd96;  end
            RES_192X64: begin g.width = 9'd192; g.height = 9'd64;  end
            RES_256X48: begin g.width = 9'd256; g.height = 9'd48;  end
            RES_384X32: begin g.width = 9'd384; g.height = 9'd32;  end
            RES_32X384: begin g.width = 9'd32;  g.height = 9'd384; end
            RES_48X256: begin g.width = 9'd48;  g.height = 9'd256; end
            RES_64X192: begin g.width = 9'd64;  g.height = 9'd192; end
            default:    begin g.width = 9'd96;  g.height = 9'd128; end
        endcase
        g.wpl = g.width[COLS_W-1:4];
        return g;
    endfunction

endpackage

// File: rtl/bscan_sync_edge.sv
module bscan_sync_edge (
    input  logic clk,
    input  logic sync_in,
    input  logic pol,
    output logic edge_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        prev_q <= sync_in;
    end

    // active edge: entering the level selected by the polarity bit
    always_comb begin
        edge_o = (sync_in == pol) && (prev_q != pol);
    end
endmodule

// File: rtl/bscan_hcount.sv
module bscan_hcount
    import bscan_pkg::*;
#(
    parameter int HCNT_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              h_edge,
    input  logic [POS_W-1:0]  hstart,
    input  logic [COLS_W-1:0] width,
    output hpos_t             hpos
);
    logic [HCNT_W-1:0] hcnt;
    logic [HCNT_W-1:0] start_ext;
    logic [HCNT_W-1:0] col_full;
    logic              past_start;

    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt <= '0;
        end else if (h_edge) begin
            hcnt <= '0;
        end else if (hcnt != {HCNT_W{1'b1}}) begin
            hcnt <= hcnt + HCNT_W'(1);
        end
    end

    always_comb begin
        start_ext   = HCNT_W'(hstart);
        past_start  = (hcnt >= start_ext);
        col_full    = hcnt - start_ext;
        hpos.active = past_start && (col_full < HCNT_W'(width));
        hpos.col    = col_full[COLS_W-1:0];
    end
endmodule

// File: rtl/bscan_vcount.sv
module bscan_vcount
    import bscan_pkg::*;
#(
    parameter int LCNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             h_edge,
    input  logic             v_edge,
    input  logic [POS_W-1:0] vstart,
    input  logic [VSZ_W-1:0] vsize,
    input  logic [ROW_W-1:0] height,
    output vpos_t            vpos
);
    logic [LCNT_W-1:0] lcnt;
    logic [LCNT_W-1:0] lcnt_next;
    logic [ROW_W-1:0]  row_q;
    logic [VSZ_W-1:0]  rep_q;
    logic              act_q;
    logic              done_q;
    logic              start_hit;
    logic              last_rep;
    logic              last_row;

    always_comb begin
        lcnt_next = (lcnt == {LCNT_W{1'b1}}) ? lcnt : lcnt + LCNT_W'(1);
        start_hit = !act_q && !done_q && (lcnt_next == LCNT_W'(vstart));
        last_rep  = (rep_q >= vsize);
        last_row  = (row_q == height - ROW_W'(1));
    end

    // done_q holds the page closed until the first vertical sync after reset
    always_ff @(posedge clk) begin
        if (rst) begin
            lcnt   <= '0;
            row_q  <= '0;
            rep_q  <= '0;
            act_q  <= 1'b0;
            done_q <= 1'b1;
        end else if (v_edge) begin
            lcnt   <= '0;
            row_q  <= '0;
            rep_q  <= '0;
            act_q  <= (vstart == '0);
            done_q <= 1'b0;
        end else if (h_edge) begin
            lcnt <= lcnt_next;
            if (act_q) begin
                if (last_rep) begin
                    rep_q <= '0;
                    if (last_row) begin
                        act_q  <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        row_q <= row_q + ROW_W'(1);
                    end
                end else begin
                    rep_q <= rep_q + VSZ_W'(1);
                end
            end else if (start_hit) begin
                act_q <= 1'b1;
                row_q <= '0;
                rep_q <= '0;
            end
        end
    end

    always_comb begin
        vpos.active = act_q;
        vpos.row    = row_q;
    end
endmodule

// File: rtl/bscan_addr_map.sv
module bscan_addr_map
    import bscan_pkg::*;
(
    input  hpos_t              hpos,
    input  vpos_t              vpos,
    input  geom_t              geom,
    input  logic               disp_en,
    output logic               in_window,
    output logic [WOFF_W-1:0]  word_off,
    output logic [BIT_W-1:0]   bit_sel
);
    logic [WOFF_W-1:0] row_w;
    logic [WOFF_W-1:0] wpl_w;
    logic [WOFF_W-1:0] colw_w;
    logic              win;

    always_comb begin
        win    = disp_en && hpos.active && vpos.active;
        row_w  = WOFF_W'(vpos.row);
        wpl_w  = WOFF_W'(geom.wpl);
        colw_w = WOFF_W'(hpos.col[COLS_W-1:4]);
        in_window = win;
        if (win) begin
            word_off = row_w * wpl_w + colw_w;
            bit_sel  = ~hpos.col[BIT_W-1:0];
        end else begin
            word_off = '0;
            bit_sel  = '0;
        end
    end
endmodule

// File: rtl/bitmap_scan_addr.sv
module bitmap_scan_addr
    import bscan_pkg::*;
#(
    parameter int HCNT_W = 11,
    parameter int LCNT_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hsync_in,
    input  logic              vsync_in,
    input  logic              hsync_pol,
    input  logic              vsync_pol,
    input  logic [2:0]        res_sel,
    input  logic [POS_W-1:0]  vstart,
    input  logic [POS_W-1:0]  hstart,
    input  logic [VSZ_W-1:0]  vsize,
    input  logic              disp_en,
    output logic              in_window,
    output logic [WOFF_W-1:0] word_off,
    output logic [BIT_W-1:0]  bit_sel
);
    localparam int NSYNC = 2;   // index 0 horizontal, 1 vertical

    logic [NSYNC-1:0] sync_v;
    logic [NSYNC-1:0] pol_v;
    logic [NSYNC-1:0] edge_v;
    logic             h_edge;
    logic             v_edge;
    geom_t            geom;
    hpos_t            hpos;
    vpos_t            vpos;

    assign sync_v = {vsync_in, hsync_in};
    assign pol_v  = {vsync_pol, hsync_pol};

    for (genvar i = 0; i < NSYNC; i++) begin : g_sync
        bscan_sync_edge u_edge (
            .clk     (clk),
            .sync_in (sync_v[i]),
            .pol     (pol_v[i]),
            .edge_o  (edge_v[i])
        );
    end

    assign h_edge = edge_v[0];
    assign v_edge = edge_v[1];

    always_comb begin
        geom = geom_of(res_e'(res_sel));
    end

    bscan_hcount #(.HCNT_W(HCNT_W)) u_hcount (
        .clk    (clk),
        .rst    (rst),
        .h_edge (h_edge),
        .hstart (hstart),
        .width  (geom.width),
        .hpos   (hpos)
    );

    bscan_vcount #(.LCNT_W(LCNT_W)) u_vcount (
        .clk    (clk),
        .rst    (rst),
        .h_edge (h_edge),
        .v_edge (v_edge),
        .vstart (vstart),
        .vsize  (vsize),
        .height (geom.height),
        .vpos   (vpos)
    );

    bscan_addr_map u_map (
        .hpos      (hpos),
        .vpos      (vpos),
        .geom      (geom),
        .disp_en   (disp_en),
        .in_window (in_window),
        .word_off  (word_off),
        .bit_sel   (bit_sel)
    );
endmodule

// File: rtl/bitmap_scan_addr_chk.sv
module bitmap_scan_addr_chk
    import bscan_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              disp_en,
    input logic [POS_W-1:0]  hstart,
    input logic [POS_W-1:0]  vstart,
    input logic              h_edge,
    input logic              v_edge,
    input logic              in_window,
    input logic [WOFF_W-1:0] word_off,
    input logic [BIT_W-1:0]  bit_sel
);
    AST_RST_QUIET: assert property (@(posedge clk)
        rst |=> !in_window);  // R1

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !in_window |-> (word_off == '0 && bit_sel == '0));  // R10

    AST_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !disp_en |-> !in_window);  // R9

    AST_WORD_RANGE: assert property (@(posedge clk) disable iff (rst)
        in_window |-> (word_off < WOFF_W'(768)));  // R7

    AST_BIT_STEP: assert property (@(posedge clk) disable iff (rst)
        (in_window && $past(in_window) && !$past(h_edge)
         && $past(bit_sel) != '0 && $stable(hstart))
        |-> (bit_sel == $past(bit_sel) - BIT_W'(1)));  // R8

    AST_HCLR: assert property (@(posedge clk) disable iff (rst)
        ($past(h_edge) && hstart == '0 && $stable(hstart) && in_window)
        |-> (bit_sel == BIT_W'(15)));  // R3

    AST_VCLR: assert property (@(posedge clk) disable iff (rst)
        (v_edge && vstart != '0) |=> !in_window);  // R4
endmodule

bind bitmap_scan_addr bitmap_scan_addr_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .disp_en   (disp_en),
    .hstart    (hstart),
    .vstart    (vstart),
    .h_edge    (h_edge),
    .v_edge    (v_edge),
    .in_window (in_window),
    .word_off  (word_off),
    .bit_sel   (bit_sel)
);

// File: tb/tb_bitmap_scan_addr.sv
module tb_bitmap_scan_addr;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hsync_in = 1'b1;
    logic       vsync_in = 1'b1;
    logic       hsync_pol = 1'b0;
    logic       vsync_pol = 1'b0;
    logic [2:0] res_sel = '0;
    logic [9:0] vstart = '0;
    logic [9:0] hstart = '0;
    logic [1:0] vsize = '0;
    logic       disp_en = 1'b0;
    logic       in_window;
    logic [9:0] word_off;
    logic [3:0] bit_sel;

    int checks = 0;
    int errors = 0;

    // bench position model
    int   mc = 0;
    int   ml = 0;
    bit   frame_seen = 0;
    logic ph = 1'b1;
    logic pv = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitmap_scan_addr dut (
        .clk(clk), .rst(rst), .hsync_in(hsync_in), .vsync_in(vsync_in),
        .hsync_pol(hsync_pol), .vsync_pol(vsync_pol), .res_sel(res_sel),
        .vstart(vstart), .hstart(hstart), .vsize(vsize), .disp_en(disp_en),
        .in_window(in_window), .word_off(word_off), .bit_sel(bit_sel)
    );

    typedef struct packed {
        logic [2:0] res;
        logic [1:0] vsz;
        logic [9:0] vst;
        logic [9:0] hst;
        logic       hp;
        logic       vp;
        logic [6:0] lines;
        logic [9:0] len;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 2'd0, 10'd2, 10'd5,  1'b0, 1'b0, 7'd6,  10'd150},
        '{3'd6, 2'd2, 10'd1, 10'd0,  1'b1, 1'b1, 7'd9,  10'd80},
        '{3'd3, 2'd0, 10'd0, 10'd3,  1'b0, 1'b1, 7'd34, 10'd400},
        '{3'd4, 2'd3, 10'd3, 10'd10, 1'b1, 1'b0, 7'd12, 10'd50},
        '{3'd7, 2'd1, 10'd0, 10'd1,  1'b1, 1'b1, 7'd6,  10'd110},
        '{3'd1, 2'd0, 10'd4, 10'd7,  1'b0, 1'b0, 7'd7,  10'd210},
        '{3'd2, 2'd1, 10'd2, 10'd0,  1'b1, 1'b0, 7'd5,  10'd270},
        '{3'd5, 2'd2, 10'd0, 10'd20, 1'b0, 1'b1, 7'd6,  10'd80},
        '{3'd3, 2'd1, 10'd1, 10'd0,  1'b0, 1'b0, 7'd67, 10'd390}
    };

    // R6 geometry table, independent of the design
    function automatic int geo_w(input logic [2:0] r);
        case (r)
            3'd0: return 128; 3'd1: return 192; 3'd2: return 256; 3'd3: return 384;
            3'd4: return 32;  3'd5: return 48;  3'd6: return 64;  default: return 96;
        endcase
    endfunction

    function automatic int geo_h(input logic [2:0] r);
        case (r)
            3'd0: return 96;  3'd1: return 64;  3'd2: return 48;  3'd3: return 32;
            3'd4: return 384; 3'd5: return 256; 3'd6: return 192; default: return 128;
        endcase
    endfunction

    task automatic check_out(input string tag);
        int ew, ewo, eb, w, h, rl, row, col;
        ew = 0; ewo = 0; eb = 0;
        w = geo_w(res_sel);
        h = geo_h(res_sel);
        if (disp_en && frame_seen && ml >= int'(vstart) && mc >= int'(hstart)) begin
            rl  = ml - int'(vstart);
            row = rl / (int'(vsize) + 1);
            col = mc - int'(hstart);
            if (row < h && col < w) begin
                ew  = 1;
                ewo = row * (w / 16) + col / 16;
                eb  = 15 - (col % 16);
            end
        end
        checks++;
        if (int'(in_window) != ew || int'(word_off) != ewo || int'(bit_sel) != eb) begin
            errors++;
            $display("FAIL %s: win/word/bit actual %0d/%0d/%0d expected %0d/%0d/%0d (L=%0d C=%0d)",
                     tag, in_window, word_off, bit_sel, ew, ewo, eb, ml, mc);
        end
    endtask

    task automatic drive_cycle(input logic h, input logic v, input string tag);
        bit he, ve;
        @(negedge clk);
        hsync_in = h;
        vsync_in = v;
        he = (h == hsync_pol) && (ph != h);
        ve = (v == vsync_pol) && (pv != v);
        if (ve) begin
            ml = 0;
            frame_seen = 1;
        end else if (he) begin
            ml = (ml < 1023) ? ml + 1 : ml;
        end
        if (he) mc = 0;
        else    mc = (mc < 2047) ? mc + 1 : mc;
        ph = h;
        pv = v;
        @(posedge clk);
        #(CLK_PERIOD/4);
        check_out(tag);
    endtask

    task automatic run_line(input int len, input bit vs_here, input string tag);
        for (int i = 0; i < len; i++) begin
            drive_cycle((i < 4) ? hsync_pol : ~hsync_pol,
                        (vs_here && i < 4) ? vsync_pol : ~vsync_pol, tag);
        end
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) drive_cycle(~hsync_pol, ~vsync_pol, "R10");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state with display enabled and syncs toggling
        disp_en = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            hsync_in = i[0];
            vsync_in = i[1];
            @(posedge clk);
            #(CLK_PERIOD/4);
            checks++;
            if (in_window !== 1'b0 || word_off !== '0 || bit_sel !== '0) begin
                errors++;
                $display("FAIL R1: reset outputs actual %0d/%0d/%0d expected 0/0/0",
                         in_window, word_off, bit_sel);
            end
        end
        @(negedge clk);
        hsync_in = 1'b1; vsync_in = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        ph = hsync_in; pv = vsync_in; mc = 0; ml = 0; frame_seen = 0;

        // R1: horizontal syncs without any vertical sync open no window
        run_line(40, 1'b0, "R1");
        run_line(40, 1'b0, "R1");

        // main table: R3 R4 R5 R6 R7 R8 R10 with coincident frame syncs
        for (int k = 0; k < NVEC; k++) begin
            disp_en = 1'b0;
            hsync_pol = VECS[k].hp;
            vsync_pol = VECS[k].vp;
            res_sel = VECS[k].res;
            vsize = VECS[k].vsz;
            vstart = VECS[k].vst;
            hstart = VECS[k].hst;
            idle_cycles(3);
            disp_en = 1'b1;
            for (int ln = 0; ln < int'(VECS[k].lines); ln++) begin
                run_line(int'(VECS[k].len), ln == 0, "R3,R4,R5,R6,R7,R8,R10");
            end
        end

        // R2: positive horizontal polarity, trailing falling edge must not clear
        disp_en = 1'b0;
        hsync_pol = 1'b1; vsync_pol = 1'b0;
        res_sel = 3'd0; vsize = 2'd0; vstart = '0; hstart = '0;
        idle_cycles(3);
        disp_en = 1'b1;
        for (int i = 0; i < 30; i++) begin
            drive_cycle((i < 6) ? 1'b1 : 1'b0, (i < 6) ? 1'b0 : 1'b1, "R2");
        end
        // R2: negative polarity, a rising edge is ignored
        disp_en = 1'b0;
        hsync_pol = 1'b0;
        idle_cycles(3);
        disp_en = 1'b1;
        for (int i = 0; i < 30; i++) begin
            drive_cycle((i < 5) ? 1'b0 : 1'b1, (i < 5) ? 1'b0 : 1'b1, "R2");
        end

        // R11: vertical sync in the middle of a line
        disp_en = 1'b0;
        res_sel = 3'd4; vsize = 2'd0; vstart = '0; hstart = '0;
        idle_cycles(3);
        disp_en = 1'b1;
        for (int ln = 0; ln < 4; ln++) run_line(45, ln == 0, "R11");
        for (int i = 0; i < 45; i++) begin
            drive_cycle((i < 4) ? 1'b0 : 1'b1, (i >= 30 && i < 34) ? 1'b0 : 1'b1, "R11");
        end
        run_line(45, 1'b0, "R11");

        // R9: display enable dropped and restored mid-window
        for (int i = 0; i < 45; i++) begin
            disp_en = !(i >= 8 && i < 20);
            drive_cycle((i < 4) ? 1'b0 : 1'b1, 1'b1, "R9");
        end
        disp_en = 1'b1;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule